// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block judges whether a recovered clock, after division down to the reference rate, runs at the same frequency as the reference clock. It counts edges of the divided clock over a measurement window of `WIN_LEN` reference cycles. It then compares that count with `WIN_LEN`. The absolute difference is the frequency error in counts.

Two thresholds give hysteresis. `UNLOCK_PPM` sets the error at which lock is lost, and the smaller `LOCK_PPM` sets the error at which lock is regained. Each threshold is converted to counts as `WIN_LEN * ppm / 1e6`, rounded down. While lock is lost, the block pulses a reacquire request to the loop every `RETRY_WINDOWS` windows. A hold input from the power-down sequencer silences both outputs. When the hold is released, the block restarts in the unlocked state.

The divided clock is counted in its own domain with a Gray-coded counter. That counter is synchronized into the reference domain, and each window takes the difference between two snapshots of it.

Top module: `freq_lock_detect`

## Requirements
- R1: During and right after reset, with `pd_hold` low, `lol` is 1 and `reacq_req` is 0.
- R2: Each window lasts `WIN_LEN` reference cycles. The error is |divided-clock edges in the window − `WIN_LEN`| and is symmetric in sign: a fast clock and a slow clock with the same offset give the same decision.
- R3: While locked, an error greater than `UNLOCK_CNT = WIN_LEN*UNLOCK_PPM/1e6` at a window end sets `lol` to 1. A stalled divided clock counts as an error of `WIN_LEN`.
- R4: While unlocked, an error of at most `LOCK_CNT = WIN_LEN*LOCK_PPM/1e6` at a window end clears `lol` to 0.
- R5: An error above `LOCK_CNT` and at most `UNLOCK_CNT` leaves `lol` unchanged, whichever state it is in.
- R6: While unlocked and not held, `reacq_req` pulses high for exactly one reference cycle. Successive pulses are exactly `RETRY_WINDOWS*WIN_LEN` reference cycles apart.
- R7: While `pd_hold` is 1, `lol` and `reacq_req` are both 0.
- R8: After `pd_hold` falls, `lol` is 1 from the next cycle until an in-band window completes.
- R9: Once an in-band divided clock is steady, `lol` is 0 no later than the end of the second window after the change.
- R10: `lol` changes only in the cycle after a window end, apart from the masking done by `pd_hold`.
- R11: `reacq_req` never pulses while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all decisions are made in this domain |
| div_clk | input | 1 | Recovered clock after division to the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_hold | input | 1 | Power-down/calibration hold, synchronous to `ref_clk` |
| lol | output | 1 | Loss-of-lock flag, active high |
| reacq_req | output | 1 | One-cycle request for the loop to reacquire |

## Verification
The divided clock runs at frequency offsets picked from three groups. Offsets well inside the lock threshold show that the lock decision is reached. Offsets well outside the unlock threshold show that lock is lost. Offsets in the band between the two thresholds show whether the hysteresis holds the previous state. Band offsets keep the sign of the previous offset, so the window that straddles a change cannot cross zero error. Random sequences over these groups are compared with a bench model of the state. Directed cases cover a stalled clock, negative offsets, the spacing and width of the reacquire pulses, and the behaviour of both outputs around a power-down hold.

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int WIN_LEN       = 16384,
  parameter int LOCK_PPM      = 300,
  parameter int UNLOCK_PPM    = 600,
  parameter int RETRY_WINDOWS = 4
) (
  input  logic ref_clk,
  input  logic div_clk,
  input  logic rst_n,
  input  logic pd_hold,
  output logic lol,
  output logic reacq_req
);
  localparam int WW         = $clog2(WIN_LEN);
  localparam int CW         = WW + 2;
  localparam int RW         = (RETRY_WINDOWS > 1) ? $clog2(RETRY_WINDOWS) : 1;
  localparam int LOCK_CNT   = int'((longint'(WIN_LEN) * LOCK_PPM) / 1000000);
  localparam int UNLOCK_CNT = int'((longint'(WIN_LEN) * UNLOCK_PPM) / 1000000);

  function automatic logic [CW-1:0] gray2bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CW-1:0] dbin, dgray, dnext;
  assign dnext = dbin + 1'b1;

  always_ff @(posedge div_clk or negedge rst_n)
    if (!rst_n) begin
      dbin  <= '0;
      dgray <= '0;
    end else begin
      dbin  <= dnext;
      dgray <= dnext ^ (dnext >> 1);
    end

  logic [CW-1:0] sync_a, sync_b, base;
  logic [WW-1:0] win_cnt;
  logic [RW-1:0] retry;
  logic          unlocked, reacq_q;

  logic [CW-1:0] cur, delta, err;
  logic          win_end, near, far, next_unl;

  assign cur      = gray2bin(sync_b);
  assign delta    = cur - base;
  assign err      = (delta >= CW'(WIN_LEN)) ? delta - CW'(WIN_LEN) : CW'(WIN_LEN) - delta;
  assign near     = err <= CW'(LOCK_CNT);
  assign far      = err >  CW'(UNLOCK_CNT);
  assign next_unl = unlocked ? !near : far;
  assign win_end  = (win_cnt == WW'(WIN_LEN - 1)) && !pd_hold;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      sync_a   <= '0;
      sync_b   <= '0;
      base     <= '0;
      win_cnt  <= '0;
      retry    <= '0;
      unlocked <= 1'b1;
      reacq_q  <= 1'b0;
    end else begin
      sync_a  <= dgray;
      sync_b  <= sync_a;
      reacq_q <= 1'b0;
      if (pd_hold) begin
        win_cnt  <= '0;
        base     <= cur;
        unlocked <= 1'b1;
        retry    <= '0;
      end else if (win_end) begin
        win_cnt  <= '0;
        base     <= cur;
        unlocked <= next_unl;
        if (!next_unl) retry <= '0;
        else if (retry == RW'(RETRY_WINDOWS - 1)) begin
          retry   <= '0;
          reacq_q <= 1'b1;
        end else retry <= retry + 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end

  assign lol       = unlocked && !pd_hold;
  assign reacq_req = reacq_q && !pd_hold;
endmodule

// File: rtl/lock_det_checker.sv
module lock_det_checker (
  input logic ref_clk,
  input logic rst_n,
  input logic pd_hold,
  input logic lol,
  input logic reacq_req,
  input logic win_end
);
  AST_PD_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pd_hold |-> (!lol && !reacq_req)); // R7
  AST_REACQ_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    reacq_req |=> !reacq_req); // R6
  AST_REACQ_UNLOCKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    reacq_req |-> lol); // R11
  AST_LOL_RISE_AT_WINDOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!pd_hold && $past(!pd_hold) && $rose(lol)) |-> $past(win_end)); // R10
  AST_LOL_FALL_AT_WINDOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!pd_hold && $fell(lol)) |-> $past(win_end)); // R10
endmodule

bind freq_lock_detect lock_det_checker u_lock_det_checker (
  .ref_clk(ref_clk), .rst_n(rst_n), .pd_hold(pd_hold),
  .lol(lol), .reacq_req(reacq_req), .win_end(win_end)
);

// File: tb/freq_lock_detect_bench.sv
`timescale 1ns/1ps
module freq_lock_detect_bench;
  localparam int WIN = 1000;
  localparam int RETRY = 3;
  localparam int SETTLE = 3 * WIN + 20;

  logic ref_clk = 1'b0, div_clk = 1'b0, rst_n = 1'b0, pd_hold = 1'b0;
  logic lol, reacq_req;
  realtime div_hp = 4.0;
  bit div_run = 1'b1;
  int total = 0, bad = 0;
  int cycle = 0, pulse_cnt = 0, last_pulse = -1, last_gap = 0, wide_cnt = 0;
  logic prev_reacq = 1'b0;

  freq_lock_detect #(.WIN_LEN(WIN), .LOCK_PPM(5000), .UNLOCK_PPM(10000),
                     .RETRY_WINDOWS(RETRY)) u_freq_lock_detect (
    .ref_clk(ref_clk), .div_clk(div_clk), .rst_n(rst_n), .pd_hold(pd_hold),
    .lol(lol), .reacq_req(reacq_req));

  always #4 ref_clk = ~ref_clk;
  always begin
    #(div_hp);
    if (div_run) div_clk = ~div_clk;
  end

  always @(negedge ref_clk) begin
    cycle++;
    if (reacq_req) begin
      pulse_cnt++;
      if (last_pulse >= 0) last_gap = cycle - last_pulse;
      last_pulse = cycle;
    end
    if (reacq_req && prev_reacq) wide_cnt++;
    prev_reacq = reacq_req;
  end

  task automatic set_off(input int off);
    div_hp = 4.0 * WIN / (WIN + off);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic model_lol(input logic prev, input int off);
    int m;
    m = (off < 0) ? -off : off;
    if (m <= 3) return 1'b0;
    if (m >= 13) return 1'b1;
    return prev;
  endfunction

  initial begin
    #1520000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic exp_lol;
    int prev_off;
    void'($urandom(32'h1F0C));
    set_off(0);
    wait_cyc(5);
    check("R1 lol in reset", lol, 1);
    check("R1 reacq in reset", reacq_req, 0);
    rst_n = 1'b1;
    wait_cyc(10);
    check("R1 lol after reset", lol, 1);
    wait_cyc(2 * WIN + 10);
    check("R9 lock after reset", lol, 0);

    set_off(20);
    wait_cyc(SETTLE);
    check("R3 fast unlock", lol, 1);
    pulse_cnt = 0; last_pulse = -1;
    wait_cyc(3 * RETRY * WIN);
    check("R6 pulse spacing", last_gap, RETRY * WIN);
    check("R6 pulse seen", int'(pulse_cnt >= 2), 1);

    set_off(3);
    wait_cyc(SETTLE);
    check("R4 relock", lol, 0);
    pulse_cnt = 0;
    wait_cyc(2 * RETRY * WIN);
    check("R11 no pulse locked", pulse_cnt, 0);

    set_off(8);
    wait_cyc(SETTLE);
    check("R5 band keeps lock", lol, 0);
    set_off(20);
    wait_cyc(SETTLE);
    check("R3 unlock again", lol, 1);
    set_off(8);
    wait_cyc(SETTLE);
    check("R5 band keeps unlock", lol, 1);

    set_off(-3);
    wait_cyc(SETTLE);
    check("R2 negative in-band lock", lol, 0);
    set_off(-20);
    wait_cyc(SETTLE);
    check("R2 slow unlock", lol, 1);

    set_off(0);
    wait_cyc(SETTLE);
    check("R4 nominal lock", lol, 0);
    div_run = 1'b0;
    wait_cyc(SETTLE);
    check("R3 stalled clock", lol, 1);
    div_run = 1'b1;

    pd_hold = 1'b1;
    wait_cyc(2);
    check("R7 lol held", lol, 0);
    pulse_cnt = 0;
    wait_cyc(2 * RETRY * WIN);
    check("R7 no pulse held", pulse_cnt, 0);
    check("R7 reacq held", reacq_req, 0);
    set_off(0);
    pd_hold = 1'b0;
    wait_cyc(1);
    check("R8 lol after release", lol, 1);
    wait_cyc(WIN / 2);
    check("R8 lol before window", lol, 1);
    wait_cyc(2 * WIN);
    check("R9 lock after release", lol, 0);

    exp_lol = 1'b0;
    prev_off = 0;
    for (int k = 0; k < 16; k++) begin
      int cat, off, sgn;
      cat = int'($urandom % 3);
      sgn = ($urandom % 2) ? 1 : -1;
      if (cat == 0) off = int'($urandom % 7) - 3;
      else if (cat == 1) off = sgn * (13 + int'($urandom % 20));
      else off = ((prev_off < 0) ? -1 : 1) * (7 + int'($urandom % 2));
      set_off(off);
      wait_cyc(SETTLE);
      exp_lol = model_lol(exp_lol, off);
      check((cat == 2) ? "R5 random band" : "R3 R4 random", lol, exp_lol);
      prev_off = off;
    end

    check("R6 pulse width", wide_cnt, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule